// File: doc/BRIEF.md
# Iterative Ones Counter

This block counts how many bits are set in a parallel operand. It does not use a combinational adder tree. The operand is parked in a register and then examined one bit per clock. In each step the least significant bit is added to a running tally and the register shifts right with a zero entering at the top. The walk ends as soon as the register holds all zeros. The number of clocks therefore depends on where the highest set bit sits, not on the operand width.

The block is driven through plain control pins. While the block is idle, a one-cycle load strobe captures the operand. Raising start then clears the tally and begins the walk. Start and done form a four-phase handshake:
- Done rises when the walk ends.
- Done stays high, with the result frozen, for as long as start remains high.
- Dropping start sends the block back to idle.

The result stays on the count output until the next start. There is no valid/ready stream here, because the operand arrives by strobe and the result is a held level. Back-pressure is therefore simply the requester keeping start high.

Top module: `ones_tally`

## Requirements
- R1: After reset, done is 0, count is 0 and the block is idle.
- R2: A load strobe is honoured only in the idle state. A strobe raised during counting or while done is high leaves the stored operand and the result unchanged.
- R3: Start, sampled high in idle with load low, clears count to 0 and begins counting. When done rises, count equals the number of 1 bits in the operand.
- R4: Let h be the index of the operand's highest set bit plus one, with h = 0 for a zero operand. Done rises at the (h+1)th rising edge after the edge that sampled start.
- R5: A zero operand gives count 0, with done asserted one edge after start is taken.
- R6: While done is high and start stays high, done and count hold. At the first edge with start low, done falls and count keeps its value.
- R7: Counting consumes the operand. A second start with no new load gives count 0.
- R8: When load and start are both high in the same idle cycle, the load is taken and that start is ignored: the block stays idle with done low.
- R9: The count output holds the full range 0 to OPND_W. An all-ones operand gives OPND_W.
- R10: Dropping start during counting does not abort the walk. Done then appears for exactly one cycle at the time given by R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Operand capture strobe, used in idle only |
| load_data | input | OPND_W | Operand to be captured |
| start | input | 1 | Begin request, held high until done is seen |
| count | output | CNT_W | Number of set bits found |
| done | output | 1 | Walk finished; held while start stays high |

## Verification
The hardest situations to reach are the strobes that arrive when the controller must not act on them. One is a load landing mid-walk or during the done phase. The other is a load coinciding with start in the same idle cycle. Both need exact cycle placement against a data-dependent latency. The bench computes each operand's highest set bit, so it knows in which cycle the walk is in flight. It injects the complemented operand on a load strobe at that cycle, or while done is held, and then proves the operand was untouched by restarting without a reload and expecting zero. Random operands are masked to random lengths so that the early-exit latency is exercised across every highest-bit position, not only near the top.

// File: rtl/ones_tally_pkg.sv
package ones_tally_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DONE  = 2'd2
  } tally_state_e;

endpackage

// File: rtl/ones_tally_shreg.sv
module ones_tally_shreg #(
  parameter int OPND_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              shift_en,
  input  logic [OPND_W-1:0] load_data,
  output logic [OPND_W-1:0] opnd,
  output logic              opnd_zero,
  output logic              opnd_lsb
);

  logic [OPND_W-1:0] opnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q <= '0;
    end else if (capture) begin
      opnd_q <= load_data;
    end else if (shift_en) begin
      opnd_q <= opnd_q >> 1;
    end
  end

  assign opnd      = opnd_q;
  assign opnd_zero = (opnd_q == '0);
  assign opnd_lsb  = opnd_q[0];

  // R2: a capture takes the presented word
  a_r2_capture_takes_word: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (opnd_q == $past(load_data)));

  // R3: each shift removes exactly the bit that was examined
  a_r3_shift_drops_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !capture) |=>
      ($countones(opnd_q) == $past($countones(opnd_q)) - int'($past(opnd_q[0]))));

endmodule

// File: rtl/ones_tally_acc.sv
module ones_tally_acc #(
  parameter int OPND_W = 16,
  parameter int CNT_W  = $clog2(OPND_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(OPND_W);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else if (step) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

  assign count = count_q;

  // R9: the tally never passes the operand width
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_MAX);

  // R3: a clear request zeroes the tally
  a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count_q == '0));

endmodule

// File: rtl/ones_tally_ctrl.sv
module ones_tally_ctrl
  import ones_tally_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         start,
  input  logic         opnd_zero,
  output tally_state_e state,
  output logic         capture,
  output logic         clear,
  output logic         shift_en,
  output logic         done
);

  tally_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (!load && start) st_d = ST_COUNT;
      ST_COUNT: if (opnd_zero)      st_d = ST_DONE;
      ST_DONE:  if (!start)         st_d = ST_IDLE;
      default:                      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign state    = st_q;
  assign capture  = (st_q == ST_IDLE) && load;
  assign clear    = (st_q == ST_IDLE) && !load && start;
  assign shift_en = (st_q == ST_COUNT) && !opnd_zero;
  assign done     = (st_q == ST_DONE);

  // R4: done is only ever entered from the counting phase
  a_r4_done_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(st_q) == ST_COUNT));

  // R8: a load in idle keeps the block idle even with start high
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && load) |=> (st_q == ST_IDLE));

  // R10: counting proceeds whatever start does
  a_r10_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_COUNT) && !opnd_zero) |=> (st_q == ST_COUNT));

endmodule

// File: rtl/ones_tally.sv
module ones_tally
  import ones_tally_pkg::*;
#(
  parameter int OPND_W = 16,
  parameter int CNT_W  = $clog2(OPND_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OPND_W-1:0] load_data,
  input  logic              start,
  output logic [CNT_W-1:0]  count,
  output logic              done
);

  tally_state_e      state;
  logic              capture;
  logic              clear;
  logic              shift_en;
  logic              opnd_zero;
  logic              opnd_lsb;
  logic [OPND_W-1:0] opnd;

  ones_tally_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .start     (start),
    .opnd_zero (opnd_zero),
    .state     (state),
    .capture   (capture),
    .clear     (clear),
    .shift_en  (shift_en),
    .done      (done)
  );

  ones_tally_shreg #(.OPND_W(OPND_W)) u_shreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .shift_en  (shift_en),
    .load_data (load_data),
    .opnd      (opnd),
    .opnd_zero (opnd_zero),
    .opnd_lsb  (opnd_lsb)
  );

  ones_tally_acc #(.OPND_W(OPND_W), .CNT_W(CNT_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .step  (shift_en && opnd_lsb),
    .count (count)
  );

  // R3: tally plus remaining set bits is conserved through the walk
  a_r3_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_COUNT) && !opnd_zero) |=>
      ((int'(count) + $countones(opnd)) == $past(int'(count) + $countones(opnd))));

  // R4: done only with the operand fully consumed
  a_r4_done_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> opnd_zero);

  // R6: result and done hold while start stays high
  a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (done && $stable(count)));

  // R2: a strobe during done leaves the operand alone
  a_r2_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (done && load) |=> $stable(opnd));

endmodule

// File: tb/ones_tally_bench.sv
`timescale 1ns/1ps
module ones_tally_bench;

  localparam int W  = 16;
  localparam int CW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [W-1:0]  load_data = '0;
  logic          start = 1'b0;
  logic [CW-1:0] count;
  logic          done;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  ones_tally #(.OPND_W(W)) u_ones_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (load_data),
    .start     (start),
    .count     (count),
    .done      (done)
  );

  function automatic int pop_of(input logic [W-1:0] d);
    int p = 0;
    for (int i = 0; i < W; i++) p += int'(d[i]);
    return p;
  endfunction

  function automatic int top_of(input logic [W-1:0] d);
    int h = 0;
    for (int i = 0; i < W; i++) if (d[i]) h = i + 1;
    return h;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // d is the operand the walk is expected to see
  task automatic run_case(input logic [W-1:0] d, input bit drop,
                          input bit poke, input bit do_load);
    int h, p, seen;
    h = top_of(d);
    p = pop_of(d);
    seen = -1;
    @(negedge clk);
    if (do_load) begin
      load = 1'b1; load_data = d;
      @(negedge clk);
      load = 1'b0;
    end
    start = 1'b1;
    for (int c = 0; c < W + 3; c++) begin
      @(negedge clk);
      if (c == 0) begin
        if (drop) start = 1'b0;
        if (poke) begin load = 1'b1; load_data = ~d; end
      end else if (c == 1) begin
        load = 1'b0;
      end
      if (done) begin seen = c; break; end
    end
    load = 1'b0;
    chk(seen == h + 1, "R4", "done latency", seen, h + 1);
    chk(int'(count) == p, "R3", "ones count", int'(count), p);
    if (h == W) chk(int'(count) == p, "R9", "full width count", int'(count), p);
    if (d == '0) chk(int'(count) == 0, "R5", "zero operand", int'(count), 0);
    if (drop) begin
      @(negedge clk);
      chk(done == 1'b0, "R10", "done one cycle", int'(done), 0);
      chk(int'(count) == p, "R10", "count kept", int'(count), p);
    end else begin
      for (int k = 0; k < 3; k++) begin
        if (k == 0 && poke) begin load = 1'b1; load_data = ~d; end
        else load = 1'b0;
        @(negedge clk);
        chk(done == 1'b1, "R6", "done held", int'(done), 1);
        chk(int'(count) == p, "R6", "count held", int'(count), p);
      end
      load = 1'b0;
      start = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R6", "done falls", int'(done), 0);
      chk(int'(count) == p, "R6", "count after release", int'(count), p);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1", "reset done", int'(done), 0);
    chk(int'(count) == 0, "R1", "reset count", int'(count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1", "idle done", int'(done), 0);

    run_case('0, 1'b0, 1'b0, 1'b1);               // R5
    run_case('1, 1'b0, 1'b0, 1'b1);               // R9
    run_case(16'h0001, 1'b1, 1'b0, 1'b1);         // R10
    run_case(16'h8000, 1'b0, 1'b0, 1'b1);
    run_case(16'hAAAA, 1'b1, 1'b1, 1'b1);         // R2 load mid-walk
    run_case('0, 1'b0, 1'b0, 1'b0);               // R7 restart, nothing loaded
    run_case(16'h5A5A, 1'b0, 1'b1, 1'b1);         // R2 load while done
    run_case('0, 1'b0, 1'b0, 1'b0);               // R2 and R7: operand untouched

    // R8: load and start together, start must be ignored
    @(negedge clk);
    load = 1'b1; load_data = 16'h0F0F; start = 1'b1;
    @(negedge clk);
    load = 1'b0; start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(done == 1'b0, "R8", "no walk from shared cycle", int'(done), 0);
      chk(int'(count) == 0, "R8", "count untouched", int'(count), 0);
    end
    run_case(16'h0F0F, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < 80; i++) begin
      d = W'($urandom);
      d = d >> ($urandom % W);
      run_case(d, bit'($urandom % 2), bit'($urandom % 2), 1'b1);
      if (i % 7 == 3) run_case('0, bit'($urandom % 2), 1'b0, 1'b0);
    end

    finish_run();
  end

endmodule